// File: doc/BRIEF.md
# BLE Advertising CRC and Whitening Encoder

This block takes a Bluetooth Low Energy advertising PDU as a byte stream (header byte, length byte, then zero to 37 payload bytes) together with a 6-bit channel index. It appends the 24-bit link-layer CRC and whitens the PDU and CRC with a channel-seeded sequence. It hands every resulting byte out in reversed bit order. A plain radio that shifts most significant bit first then puts the bits on air in the order the link layer expects. Preamble and access address are added elsewhere.

Both sides use valid/ready handshakes, and each side carries a last-byte marker. The first byte accepted after reset, or after the previous packet's final CRC byte, starts a packet. At that byte the CRC register and the whitening register are reloaded and the channel index is captured. The input marker ends the PDU, and the block then emits three CRC bytes on its own. The output marker is set on the third of them. The output stage is a single register, so each byte appears one cycle after it is accepted. Full throughput is sustained while the consumer is ready.

Top module: `ble_adv_encoder`

## Requirements
- R1: After reset, `m_valid` is low and `s_ready` is high.
- R2: Every accepted input byte leaves exactly once, in arrival order, as its whitened value with bits reversed: output bit 7 holds whitened bit 0. No output byte appears without an input byte or a CRC byte behind it.
- R3: The CRC is 24 bits wide and is seeded with 0x555555 at the first byte of a packet. It consumes every PDU byte least significant bit first. Per bit the register shifts left by one, the feedback is the old bit 23 XOR the data bit, and a feedback of 1 XORs the low 16 bits with 0x065B.
- R4: After the input byte flagged last, exactly three CRC bytes follow in the order register bits 23:16, 15:8, 7:0. Each is bit-reversed, then whitened, then bit-reversed again. `m_last` is high only on the third of them. `s_ready` stays low until the third CRC byte is in the output register.
- R5: Whitening uses a 7-bit LFSR with polynomial x^7 + x^4 + 1 that advances once per bit, least significant data bit first. Its state bit 6 is XORed into the data bit and fed back into bit 0 and bit 4. It is seeded with channel bit 0 in state bit 6, channel bit 1 in bit 5, and so on down to channel bit 5 in bit 1, with bit 0 forced to 1.
- R6: `s_chan` is sampled only with the first byte of a packet. Its value during later bytes has no effect on the output.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` hold their values. No byte is lost or repeated under any stall pattern on either side.
- R8: Every packet reloads both the CRC and the whitening register. Two identical packets sent back to back on the same channel produce identical output.
- R9: PDUs of one byte, two bytes (empty payload) and 39 bytes (37-byte payload) are encoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Block accepts an input byte |
| s_data | input | 8 | PDU byte |
| s_last | input | 1 | Marks the final PDU byte |
| s_chan | input | 6 | Channel index, sampled with the first byte of a packet |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Consumer accepts the output byte |
| m_data | output | 8 | Whitened, bit-reversed byte |
| m_last | output | 1 | Marks the final CRC byte |

## Verification
The bound checker checks the following on every cycle:
- the idle state after reset;
- the output holding steady under backpressure;
- that no input is accepted while the CRC tail is pending;
- that each packet's output byte count equals its input byte count plus three, with the marker on the final byte.

The bit-level values are checked only by the bench's scenarios, where a behavioural model predicts each byte:
- the CRC value;
- the seeding and stepping of the whitening sequence;
- the per-byte bit reversal;
- that the channel is ignored after the first byte;
- the reload between back-to-back packets.

// File: rtl/ble_adv_pkg.sv
package ble_adv_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned CRC_W      = 24;
    localparam int unsigned WHT_W      = 7;
    localparam int unsigned CHAN_W     = 6;
    localparam int unsigned CRC_BYTES  = CRC_W / BYTE_W;
    localparam int unsigned TAIL_IDX_W = (CRC_BYTES > 1) ? $clog2(CRC_BYTES) : 1;

    typedef enum logic [0:0] {
        ST_BODY = 1'b0,   // accepting PDU bytes (or waiting for the next packet)
        ST_TAIL = 1'b1    // emitting CRC bytes
    } enc_state_e;

    typedef struct packed {
        enc_state_e              state;
        logic                    sop;
        logic [CRC_W-1:0]        crc;
        logic [WHT_W-1:0]        lfsr;
        logic [TAIL_IDX_W-1:0]   tail_idx;
        logic                    out_valid;
        logic [BYTE_W-1:0]       out_data;
        logic                    out_last;
    } enc_reg_t;

    function automatic logic [BYTE_W-1:0] bit_flip(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = v[BYTE_W-1-i];
        end
        return r;
    endfunction

    // Channel bit i lands in state bit (WHT_W-1-i); state bit 0 is forced high.
    function automatic logic [WHT_W-1:0] wht_seed(input logic [CHAN_W-1:0] ch);
        logic [WHT_W-1:0] s;
        s = '0;
        for (int i = 0; i < CHAN_W; i++) begin
            s[WHT_W-1-i] = ch[i];
        end
        s[0] = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/ble_crc_byte.sv
module ble_crc_byte
    import ble_adv_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 24'h00065B
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);

    logic [BYTE_W:0][CRC_W-1:0] stage;

    assign stage[0] = crc_i;

    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        logic fb;
        assign fb           = stage[b][CRC_W-1] ^ data_i[b];
        assign stage[b+1]   = {stage[b][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_o = stage[BYTE_W];

endmodule

// File: rtl/ble_whiten_byte.sv
module ble_whiten_byte
    import ble_adv_pkg::*;
#(
    parameter logic [WHT_W-1:0] FB_MASK = 7'h11
) (
    input  logic [WHT_W-1:0]  lfsr_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [WHT_W-1:0]  lfsr_o,
    output logic [BYTE_W-1:0] data_o
);

    logic [BYTE_W:0][WHT_W-1:0] stage;

    assign stage[0] = lfsr_i;

    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        logic key;
        assign key        = stage[b][WHT_W-1];
        assign data_o[b]  = data_i[b] ^ key;
        assign stage[b+1] = {stage[b][WHT_W-2:0], 1'b0} ^ (key ? FB_MASK : '0);
    end

    assign lfsr_o = stage[BYTE_W];

endmodule

// File: rtl/ble_adv_encoder.sv
module ble_adv_encoder
    import ble_adv_pkg::*;
#(
    parameter logic [CRC_W-1:0] CRC_INIT = 24'h555555,
    parameter logic [CRC_W-1:0] CRC_POLY = 24'h00065B,
    parameter logic [WHT_W-1:0] WHT_FB   = 7'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    input  logic [5:0]        s_chan,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [7:0]        m_data,
    output logic              m_last
);

    localparam logic [TAIL_IDX_W-1:0] LAST_TAIL = TAIL_IDX_W'(CRC_BYTES - 1);

    enc_reg_t q, d;

    logic              slot_free;
    logic              in_fire;
    logic              in_tail;
    logic [CRC_W-1:0]  crc_src;
    logic [CRC_W-1:0]  crc_new;
    logic [CRC_W-1:0]  crc_shifted;
    logic [BYTE_W-1:0] tail_raw;
    logic [WHT_W-1:0]  wht_src;
    logic [WHT_W-1:0]  wht_new;
    logic [BYTE_W-1:0] wht_in;
    logic [BYTE_W-1:0] wht_out;

    assign in_tail     = (q.state == ST_TAIL);
    assign slot_free   = !q.out_valid || m_ready;
    assign s_ready     = !in_tail && slot_free;
    assign in_fire     = s_valid && s_ready;

    assign crc_src     = q.sop ? CRC_INIT : q.crc;
    assign crc_shifted = q.crc << {q.tail_idx, 3'b000};
    assign tail_raw    = crc_shifted[CRC_W-1 -: BYTE_W];

    assign wht_src     = in_tail ? q.lfsr : (q.sop ? wht_seed(s_chan) : q.lfsr);
    assign wht_in      = in_tail ? bit_flip(tail_raw) : s_data;

    ble_crc_byte #(
        .POLY   (CRC_POLY)
    ) crc_u (
        .crc_i  (crc_src),
        .data_i (s_data),
        .crc_o  (crc_new)
    );

    ble_whiten_byte #(
        .FB_MASK(WHT_FB)
    ) wht_u (
        .lfsr_i (wht_src),
        .data_i (wht_in),
        .lfsr_o (wht_new),
        .data_o (wht_out)
    );

    always_comb begin
        d = q;
        if (q.out_valid && m_ready) begin
            d.out_valid = 1'b0;
            d.out_last  = 1'b0;
        end
        if (in_fire) begin
            d.crc       = crc_new;
            d.lfsr      = wht_new;
            d.sop       = 1'b0;
            d.out_valid = 1'b1;
            d.out_data  = bit_flip(wht_out);
            d.out_last  = 1'b0;
            if (s_last) begin
                d.state    = ST_TAIL;
                d.tail_idx = '0;
            end
        end else if (in_tail && slot_free) begin
            d.lfsr      = wht_new;
            d.out_valid = 1'b1;
            d.out_data  = bit_flip(wht_out);
            d.out_last  = (q.tail_idx == LAST_TAIL);
            if (q.tail_idx == LAST_TAIL) begin
                d.state = ST_BODY;
                d.sop   = 1'b1;
            end else begin
                d.tail_idx = q.tail_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state     <= ST_BODY;
            q.sop       <= 1'b1;
            q.crc       <= CRC_INIT;
            q.lfsr      <= '0;
            q.tail_idx  <= '0;
            q.out_valid <= 1'b0;
            q.out_data  <= '0;
            q.out_last  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign m_valid = q.out_valid;
    assign m_data  = q.out_data;
    assign m_last  = q.out_last;

endmodule

// File: rtl/ble_adv_encoder_chk.sv
module ble_adv_encoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       s_valid,
    input logic       s_ready,
    input logic       s_last,
    input logic       m_valid,
    input logic       m_ready,
    input logic [7:0] m_data,
    input logic       m_last
);

    logic       in_fire, out_fire, pkt_end;
    logic [7:0] in_cnt_q, out_cnt_q;
    logic       tail_q;

    assign in_fire  = s_valid && s_ready;
    assign out_fire = m_valid && m_ready;
    assign pkt_end  = out_fire && m_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_cnt_q  <= '0;
            out_cnt_q <= '0;
            tail_q    <= 1'b0;
        end else begin
            if (pkt_end) begin
                in_cnt_q  <= in_fire ? 8'd1 : 8'd0;
                out_cnt_q <= '0;
            end else begin
                in_cnt_q  <= in_cnt_q + (in_fire ? 8'd1 : 8'd0);
                out_cnt_q <= out_cnt_q + (out_fire ? 8'd1 : 8'd0);
            end
            if (in_fire && s_last)
                tail_q <= 1'b1;
            else if (pkt_end)
                tail_q <= 1'b0;
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!m_valid && s_ready));

    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

    a_r4_tail_count: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> ((out_cnt_q + 8'd1) == (in_cnt_q + 8'd3)));

    a_r4_no_input_in_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_q && !pkt_end) |-> !s_ready);

    a_r4_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        m_last |-> m_valid);

    a_r2_no_extra_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        out_fire |-> (out_cnt_q < (in_cnt_q + 8'd3)));

endmodule

bind ble_adv_encoder ble_adv_encoder_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_last  (s_last),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .m_last  (m_last)
);

// File: tb/ble_adv_encoder_tb.sv
module ble_adv_encoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_valid = 1'b0;
    logic       s_ready;
    logic [7:0] s_data = '0;
    logic       s_last = 1'b0;
    logic [5:0] s_chan = '0;
    logic       m_valid;
    logic       m_ready = 1'b1;
    logic [7:0] m_data;
    logic       m_last;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int ready_mode = 0;       // 0: always ready, 1: random stalls
    string scen = "";

    // reference model state
    bit        mdl_in_pkt = 0;
    int        mdl_crc;
    logic [7:0] mdl_coeff;
    logic [7:0] exp_data[$];
    bit        exp_last[$];
    string     exp_tag[$];

    bit        prev_stall = 0;
    logic [7:0] prev_data;
    logic      prev_last;

    always #4 clk = ~clk;

    ble_adv_encoder dut_i (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_last(s_last), .s_chan(s_chan),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
    );

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = v[i];
        return r;
    endfunction

    function automatic void report;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired (all requirements) got=hang exp=finish");
            report();
            $finish;
        end
    end

    // R3: bitwise CRC step, R5: whitening with an 8-bit coefficient register
    task automatic mdl_byte(input logic [7:0] b, input bit is_crc, input bit lst);
        logic [7:0] w;
        w = b;
        for (int i = 0; i < 8; i++) begin
            if (mdl_coeff[7]) begin
                mdl_coeff = mdl_coeff ^ 8'h11;
                w[i] = ~w[i];
            end
            mdl_coeff = mdl_coeff << 1;
        end
        exp_data.push_back(rev8(w));
        exp_last.push_back(lst);
        exp_tag.push_back(is_crc ? "R3 R4" : "R2 R5");
    endtask

    task automatic mdl_accept(input logic [7:0] b, input bit lst, input logic [5:0] ch);
        if (!mdl_in_pkt) begin
            mdl_crc   = 'h555555;
            mdl_coeff = rev8({2'b00, ch}) | 8'h02;
            mdl_in_pkt = 1;
        end
        for (int i = 0; i < 8; i++) begin
            int top;
            top = (mdl_crc >> 23) & 1;
            mdl_crc = (mdl_crc << 1) & 'hFFFFFF;
            if (top != ((b >> i) & 1)) mdl_crc = mdl_crc ^ 'h00065B;
        end
        mdl_byte(b, 0, 0);
        if (lst) begin
            mdl_byte(rev8(8'((mdl_crc >> 16) & 'hFF)), 1, 0);
            mdl_byte(rev8(8'((mdl_crc >> 8) & 'hFF)), 1, 0);
            mdl_byte(rev8(8'(mdl_crc & 'hFF)), 1, 1);
            mdl_in_pkt = 0;
        end
    endtask

    // Called at negedge + 1: signals stable, handshakes are those of the next edge.
    task automatic eval(output bit accepted);
        accepted = 0;
        if (prev_stall) begin
            n_tests++;
            if (!(m_valid && m_data == prev_data && m_last == prev_last)) begin
                n_fail++;
                $display("FAIL R7 [%s] hold: got v=%0b d=%02h l=%0b exp v=1 d=%02h l=%0b",
                         scen, m_valid, m_data, m_last, prev_data, prev_last);
            end
        end
        prev_stall = m_valid && !m_ready;
        prev_data  = m_data;
        prev_last  = m_last;
        if (s_valid && s_ready) begin
            mdl_accept(s_data, s_last, s_chan);
            accepted = 1;
        end
        if (m_valid && m_ready) begin
            n_tests++;
            if (exp_data.size() == 0) begin
                n_fail++;
                $display("FAIL R2 [%s] unexpected byte: got %02h exp none", scen, m_data);
            end else begin
                logic [7:0] ed;
                bit el;
                string et;
                ed = exp_data.pop_front();
                el = exp_last.pop_front();
                et = exp_tag.pop_front();
                if (m_data !== ed || m_last !== el) begin
                    n_fail++;
                    $display("FAIL %s [%s]: got d=%02h l=%0b exp d=%02h l=%0b",
                             et, scen, m_data, m_last, ed, el);
                end
            end
        end
    endtask

    task automatic drive_ready;
        if (ready_mode == 0) m_ready = 1'b1;
        else m_ready = ($urandom_range(0, 3) != 0);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit lst, input logic [5:0] ch);
        bit acc;
        acc = 0;
        while (!acc) begin
            @(negedge clk);
            s_valid = 1'b1; s_data = b; s_last = lst; s_chan = ch;
            drive_ready();
            #1;
            eval(acc);
        end
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
        drive_ready();
        #1;
        eval(acc);
    endtask

    task automatic send_pkt(input logic [7:0] pkt[$], input logic [5:0] ch,
                            input logic [5:0] ch_later, input bit gaps);
        for (int i = 0; i < pkt.size(); i++) begin
            send_byte(pkt[i], (i == pkt.size() - 1), (i == 0) ? ch : ch_later);
            if (gaps && $urandom_range(0, 2) == 0) begin
                for (int g = 0; g < $urandom_range(1, 3); g++) begin
                    bit acc;
                    @(negedge clk);
                    drive_ready();
                    #1;
                    eval(acc);
                end
            end
        end
    endtask

    task automatic drain;
        int guard;
        guard = 0;
        while ((exp_data.size() != 0 || m_valid) && guard < 200) begin
            bit acc;
            @(negedge clk);
            s_valid = 1'b0;
            drive_ready();
            #1;
            eval(acc);
            guard++;
        end
        n_tests++;
        if (exp_data.size() != 0) begin
            n_fail++;
            $display("FAIL R4 [%s] missing bytes: got %0d left exp 0", scen, exp_data.size());
        end
    endtask

    function automatic void mk_pkt(ref logic [7:0] p[$], input int plen, input int salt);
        p.delete();
        p.push_back(8'h42);
        p.push_back(8'(plen));
        for (int i = 0; i < plen; i++) p.push_back(8'((i * 37 + salt) & 'hFF));
    endfunction

    initial begin
        logic [7:0] pkt[$];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        n_tests++;
        if (m_valid !== 1'b0 || s_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 reset: got v=%0b r=%0b exp v=0 r=1", m_valid, s_ready);
        end

        scen = "R2 R3 typical";
        ready_mode = 0;
        mk_pkt(pkt, 9, 3);
        send_pkt(pkt, 6'd37, 6'd37, 0);
        drain();

        scen = "R9 empty payload";
        mk_pkt(pkt, 0, 0);
        send_pkt(pkt, 6'd0, 6'd0, 0);
        drain();

        scen = "R9 R7 max payload stalls";
        ready_mode = 1;
        mk_pkt(pkt, 37, 11);
        send_pkt(pkt, 6'd39, 6'd39, 1);
        drain();

        scen = "R6 channel change mid packet";
        mk_pkt(pkt, 12, 90);
        send_pkt(pkt, 6'd38, 6'd5, 0);
        drain();

        scen = "R8 back to back";
        ready_mode = 0;
        mk_pkt(pkt, 6, 200);
        send_pkt(pkt, 6'd21, 6'd21, 0);
        send_pkt(pkt, 6'd21, 6'd21, 0);
        drain();

        scen = "R9 single byte";
        pkt.delete();
        pkt.push_back(8'hA5);
        send_pkt(pkt, 6'd63, 6'd63, 0);
        drain();

        scen = "R7 random traffic";
        ready_mode = 1;
        for (int k = 0; k < 20; k++) begin
            mk_pkt(pkt, $urandom_range(0, 37), $urandom_range(0, 255));
            send_pkt(pkt, 6'($urandom_range(0, 63)), 6'($urandom_range(0, 63)), 1);
        end
        drain();

        report();
        $finish;
    end

endmodule